// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Function Routing

This block controls a group of up to eight general-purpose pins behind a small register interface. One register set holds a bit per pin for each of these: output data, direction, function select, extended function select, pull enable, pull polarity, two input-threshold bits and drive strength. A global input-enable register gates all sampled pin inputs. The block drives an abstract pad model with an output value, an output enable, pull-up and pull-down enables, a 2-bit threshold code and a weak-drive flag for each pin.

Each pin serves either as plain I/O or as one of two peripheral resources. A resource supplies its own output value and output enable, and those replace the data register at the pad. The resource gets the synchronized pin level back. The data-register read path depends on the access type. A plain read of an I/O pin in input direction returns the pin. A read that belongs to a read-modify-write always returns the stored bits. A separate read-only address always returns the sampled pin level.

A stop-mode input puts every pin into high impedance and turns all pulls off. The pull polarity bit is write-protected while the pull is enabled. The intended programming order is to disable the pull, set the polarity, then enable it again.

Top module: `gpio_fnmux_port`

## Requirements
- R1: After synchronous reset every register reads 0, and `pad_oe`, `pad_pu`, `pad_pd` and `bus_rdata` are 0.
- R2: The input-enable register is at address 9. Only bits 1:0 are stored and bits 7:2 always read 0. Bit 0 enables the inputs of every pin. Bit 1 alone enables only the boot-link pins, given by `BOOT_MASK` (default pins 0 and 1). A disabled pin's sampled level is 0 on every read path and every resource input.
- R3: A plain read of the data register (address 0) returns, for each bit, the sampled pin if that pin is plain I/O in input direction. Otherwise it returns the stored data bit.
- R4: A read with `bus_rmw`=1 at address 0 returns the stored data bits whatever the direction and function settings.
- R5: A write to address 0 always updates the stored data. For a plain I/O pin, `pad_oe` equals the direction bit (address 1, 1 = output), and the stored bit appears on `pad_out` while that bit is set.
- R6: Address 10 is read-only and returns the gated, synchronized pin levels. A write to it changes nothing.
- R7: Function select (address 2) bit 0 means plain I/O. With the function bit at 1, the extended bit (address 3) at 0 selects resource 1 and at 1 selects resource 2. The selected resource's output and output enable drive `pad_out`/`pad_oe`. `res1_in`/`res2_in` carry the sampled pin only for pins routed to that resource and are 0 elsewhere.
- R8: With pull enable (address 4) at 0 there is no pull. With enable at 1, polarity (address 5) at 0 gives `pad_pd` and polarity at 1 gives `pad_pu`.
- R9: A write to a polarity bit takes effect only if that pin's pull-enable bit is 0. Otherwise the stored bit is kept.
- R10: Pulls are forced off for any pin whose `pad_oe` is 1, and for all pins while `hiz_stop` is 1.
- R11: While `hiz_stop` is 1, all `pad_oe` bits are 0.
- R12: `pad_lvl[2i+1:2i]` = {level bit i (address 6), extended level bit i (address 7)}. The codes are 00 CMOS hysteresis A, 01 TTL, 10 automotive, 11 CMOS hysteresis B. `pad_weak` mirrors address 8 (1 = weak drive).
- R13: `bus_rdata` is valid from the clock edge that samples `bus_rd`. Pad outputs change one edge after the register write or input change that causes them. A pin change reaches reads two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hiz_stop | input | 1 | Stop mode: all pins high impedance, pulls off |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Registered read data |
| pad_in | input | PINS | Raw pin levels from the pad |
| pad_out | output | PINS | Output value to the pad |
| pad_oe | output | PINS | Output enable to the pad |
| pad_pu | output | PINS | Pull-up enable |
| pad_pd | output | PINS | Pull-down enable |
| pad_lvl | output | 2*PINS | Input threshold code per pin |
| pad_weak | output | PINS | Weak drive select per pin |
| res1_out | input | PINS | Resource 1 output values |
| res1_oe | input | PINS | Resource 1 output enables |
| res2_out | input | PINS | Resource 2 output values |
| res2_oe | input | PINS | Resource 2 output enables |
| res1_in | output | PINS | Sampled pins routed to resource 1 |
| res2_in | output | PINS | Sampled pins routed to resource 2 |

## Verification
Read results are due at the edge that samples the strobe. The bench's monitor therefore pops an expected value shortly after each edge at which it saw `bus_rd` high. Pad outputs are due one edge after the write that changes them, so pad checks wait one further falling edge after a write completes. One check at the half-cycle before that confirms the old value still holds. Pin changes need two edges through the synchronizer. The bench reads back-to-back across a pin change and expects the old value twice before the new one.

// File: rtl/gpio_fnmux_pkg.sv
package gpio_fnmux_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA  = 4'd0,
    RA_DIR   = 4'd1,
    RA_FUNC  = 4'd2,
    RA_XFUNC = 4'd3,
    RA_PEN   = 4'd4,
    RA_PSEL  = 4'd5,
    RA_LVL   = 4'd6,
    RA_XLVL  = 4'd7,
    RA_DRIVE = 4'd8,
    RA_INEN  = 4'd9,
    RA_PIN   = 4'd10
  } reg_addr_e;

  typedef enum logic [1:0] {
    LVL_CMOS_A = 2'b00,
    LVL_TTL    = 2'b01,
    LVL_AUTO   = 2'b10,
    LVL_CMOS_B = 2'b11
  } in_level_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int          PINS      = 8,
  parameter logic [PINS-1:0] BOOT_MASK = 'h3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_raw,
  input  logic [1:0]      in_en,
  output logic [PINS-1:0] pin_q
);

  logic [PINS-1:0] meta_q;
  logic [PINS-1:0] sync_q;
  logic [PINS-1:0] pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_gate
    if (BOOT_MASK[i]) begin : g_boot
      assign pass[i] = in_en[0] | in_en[1];
    end else begin : g_plain
      assign pass[i] = in_en[0];
    end
  end

  assign pin_q = sync_q & pass;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_fnmux_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_q,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   func_q,
  output logic [PINS-1:0]   xfunc_q,
  output logic [PINS-1:0]   pen_q,
  output logic [PINS-1:0]   psel_q,
  output logic [PINS-1:0]   lvl_q,
  output logic [PINS-1:0]   xlvl_q,
  output logic [PINS-1:0]   drive_q,
  output logic [1:0]        inen_q
);

  logic [PINS-1:0] pin_view;
  logic [PINS-1:0] data_view;
  logic [PINS-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      func_q  <= '0;
      xfunc_q <= '0;
      pen_q   <= '0;
      psel_q  <= '0;
      lvl_q   <= '0;
      xlvl_q  <= '0;
      drive_q <= '0;
      inen_q  <= '0;
    end else if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        RA_DATA:  data_q  <= bus_wdata;
        RA_DIR:   dir_q   <= bus_wdata;
        RA_FUNC:  func_q  <= bus_wdata;
        RA_XFUNC: xfunc_q <= bus_wdata;
        RA_PEN:   pen_q   <= bus_wdata;
        RA_PSEL:  psel_q  <= (psel_q & pen_q) | (bus_wdata & ~pen_q);
        RA_LVL:   lvl_q   <= bus_wdata;
        RA_XLVL:  xlvl_q  <= bus_wdata;
        RA_DRIVE: drive_q <= bus_wdata;
        RA_INEN:  inen_q  <= bus_wdata[1:0];
        default:  ;
      endcase
    end
  end

  // Plain reads see the pin only on plain I/O inputs; RMW reads never do.
  assign pin_view  = bus_rmw ? '0 : (~func_q & ~dir_q);
  assign data_view = (pin_q & pin_view) | (data_q & ~pin_view);

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_DATA:  rd_mux = data_view;
      RA_DIR:   rd_mux = dir_q;
      RA_FUNC:  rd_mux = func_q;
      RA_XFUNC: rd_mux = xfunc_q;
      RA_PEN:   rd_mux = pen_q;
      RA_PSEL:  rd_mux = psel_q;
      RA_LVL:   rd_mux = lvl_q;
      RA_XLVL:  rd_mux = xlvl_q;
      RA_DRIVE: rd_mux = drive_q;
      RA_INEN:  rd_mux = {{(PINS-2){1'b0}}, inen_q};
      RA_PIN:   rd_mux = pin_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9: polarity bits with the pull enabled never change
  a_r9_psel_locked: assert property (@(posedge clk) disable iff (rst)
    ((psel_q ^ $past(psel_q)) & $past(pen_q)) == '0);

  // R4: an RMW read of the data register returns the stored bits
  a_r4_rmw_stored: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_rmw && bus_addr == RA_DATA) |-> bus_rdata == $past(data_q));

  // R2: reserved enable bits always read 0
  a_r2_inen_reserved: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == RA_INEN) |-> bus_rdata[PINS-1:2] == '0);

  // R6: direct-read address returns the sampled pins
  a_r6_direct_pin: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == RA_PIN) |-> bus_rdata == $past(pin_q));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hiz_stop,
  input  logic [PINS-1:0]   data_q,
  input  logic [PINS-1:0]   dir_q,
  input  logic [PINS-1:0]   func_q,
  input  logic [PINS-1:0]   xfunc_q,
  input  logic [PINS-1:0]   pen_q,
  input  logic [PINS-1:0]   psel_q,
  input  logic [PINS-1:0]   lvl_q,
  input  logic [PINS-1:0]   xlvl_q,
  input  logic [PINS-1:0]   drive_q,
  input  logic [PINS-1:0]   pin_q,
  input  logic [PINS-1:0]   res1_out,
  input  logic [PINS-1:0]   res1_oe,
  input  logic [PINS-1:0]   res2_out,
  input  logic [PINS-1:0]   res2_oe,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd,
  output logic [2*PINS-1:0] pad_lvl,
  output logic [PINS-1:0]   pad_weak,
  output logic [PINS-1:0]   res1_in,
  output logic [PINS-1:0]   res2_in
);

  logic [PINS-1:0]   sel_r1, sel_r2;
  logic [PINS-1:0]   out_d, oe_d, pu_d, pd_d;
  logic [2*PINS-1:0] lvl_d;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign sel_r1[i] = func_q[i] & ~xfunc_q[i];
    assign sel_r2[i] = func_q[i] &  xfunc_q[i];

    always_comb begin
      if (sel_r2[i]) begin
        out_d[i] = res2_out[i];
        oe_d[i]  = res2_oe[i];
      end else if (sel_r1[i]) begin
        out_d[i] = res1_out[i];
        oe_d[i]  = res1_oe[i];
      end else begin
        out_d[i] = data_q[i];
        oe_d[i]  = dir_q[i];
      end
      if (hiz_stop) oe_d[i] = 1'b0;
      pu_d[i] = pen_q[i] &  psel_q[i] & ~oe_d[i] & ~hiz_stop;
      pd_d[i] = pen_q[i] & ~psel_q[i] & ~oe_d[i] & ~hiz_stop;
    end

    assign lvl_d[2*i+1] = lvl_q[i];
    assign lvl_d[2*i]   = xlvl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= '0;
      pad_oe   <= '0;
      pad_pu   <= '0;
      pad_pd   <= '0;
      pad_lvl  <= '0;
      pad_weak <= '0;
    end else begin
      pad_out  <= out_d;
      pad_oe   <= oe_d;
      pad_pu   <= pu_d;
      pad_pd   <= pd_d;
      pad_lvl  <= lvl_d;
      pad_weak <= drive_q;
    end
  end

  assign res1_in = pin_q & sel_r1;
  assign res2_in = pin_q & sel_r2;

  // R11: stop mode leaves no output enabled
  a_r11_hiz_no_oe: assert property (@(posedge clk) disable iff (rst)
    $past(hiz_stop) |-> pad_oe == '0);

  // R10: no pull on a driven pin
  a_r10_pull_off_driven: assert property (@(posedge clk) disable iff (rst)
    ((pad_pu | pad_pd) & pad_oe) == '0);

  // R8: never both pulls on one pin
  a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  // R7: a pin feeds at most one resource
  a_r7_res_in_disjoint: assert property (@(posedge clk) disable iff (rst)
    (res1_in & res2_in) == '0);

endmodule

// File: rtl/gpio_fnmux_port.sv
module gpio_fnmux_port
  import gpio_fnmux_pkg::*;
#(
  parameter int              PINS      = 8,
  parameter logic [PINS-1:0] BOOT_MASK = 'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hiz_stop,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_rmw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd,
  output logic [2*PINS-1:0] pad_lvl,
  output logic [PINS-1:0]   pad_weak,
  input  logic [PINS-1:0]   res1_out,
  input  logic [PINS-1:0]   res1_oe,
  input  logic [PINS-1:0]   res2_out,
  input  logic [PINS-1:0]   res2_oe,
  output logic [PINS-1:0]   res1_in,
  output logic [PINS-1:0]   res2_in
);

  logic [PINS-1:0] pin_q;
  logic [PINS-1:0] data_q, dir_q, func_q, xfunc_q, pen_q, psel_q;
  logic [PINS-1:0] lvl_q, xlvl_q, drive_q;
  logic [1:0]      inen_q;

  gpio_in_sync #(.PINS(PINS), .BOOT_MASK(BOOT_MASK)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (pad_in),
    .in_en   (inen_q),
    .pin_q   (pin_q)
  );

  gpio_regfile #(.PINS(PINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rmw   (bus_rmw),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_q     (pin_q),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .func_q    (func_q),
    .xfunc_q   (xfunc_q),
    .pen_q     (pen_q),
    .psel_q    (psel_q),
    .lvl_q     (lvl_q),
    .xlvl_q    (xlvl_q),
    .drive_q   (drive_q),
    .inen_q    (inen_q)
  );

  gpio_pad_drive #(.PINS(PINS)) u_pads (
    .clk      (clk),
    .rst      (rst),
    .hiz_stop (hiz_stop),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .func_q   (func_q),
    .xfunc_q  (xfunc_q),
    .pen_q    (pen_q),
    .psel_q   (psel_q),
    .lvl_q    (lvl_q),
    .xlvl_q   (xlvl_q),
    .drive_q  (drive_q),
    .pin_q    (pin_q),
    .res1_out (res1_out),
    .res1_oe  (res1_oe),
    .res2_out (res2_out),
    .res2_oe  (res2_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .pad_lvl  (pad_lvl),
    .pad_weak (pad_weak),
    .res1_in  (res1_in),
    .res2_in  (res2_in)
  );

endmodule

// File: tb/gpio_fnmux_port_tb_top.sv
module gpio_fnmux_port_tb_top;

  localparam int PINS = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            hiz_stop = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
  logic [3:0]      bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_weak;
  logic [2*PINS-1:0] pad_lvl;
  logic [PINS-1:0] res1_out = '0, res1_oe = '0, res2_out = '0, res2_oe = '0;
  logic [PINS-1:0] res1_in, res2_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [PINS-1:0] exp_q[$];
  string           tag_q[$];
  logic            mon_rd;

  always #10 clk = ~clk;

  gpio_fnmux_port #(.PINS(PINS)) dut_i (
    .clk(clk), .rst(rst), .hiz_stop(hiz_stop),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_lvl(pad_lvl), .pad_weak(pad_weak),
    .res1_out(res1_out), .res1_oe(res1_oe), .res2_out(res2_out), .res2_oe(res2_oe),
    .res1_in(res1_in), .res2_in(res2_in)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected item per sampled read strobe
  always @(posedge clk) begin
    mon_rd = bus_rd & ~rst;
    #2;
    if (mon_rd) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
      end else begin
        check({8'h0, bus_rdata}, {8'h0, exp_q.pop_front()}, tag_q.pop_front());
      end
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic rmw,
                        input logic [PINS-1:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b0; bus_rmw = rmw; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0; bus_rmw = 1'b0;
  endtask

  // Pad outputs are registered: let one more edge pass after a write.
  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [2*PINS-1:0] lvl_code(input logic [PINS-1:0] l,
                                                 input logic [PINS-1:0] x);
    logic [2*PINS-1:0] r;
    for (int i = 0; i < PINS; i++) r[2*i +: 2] = {l[i], x[i]};
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({8'h0, pad_oe}, 16'h0, "R1 pad_oe");
    check({8'h0, pad_pu | pad_pd}, 16'h0, "R1 pulls");
    check({8'h0, bus_rdata}, 16'h0, "R1 rdata");
    rd_reg(4'd9, 1'b0, 8'h00, "R1 inen reset");
    rd_reg(4'd1, 1'b0, 8'h00, "R1 dir reset");

    // R2 reserved bits and gating
    wr_reg(4'd9, 8'hFF);
    rd_reg(4'd9, 1'b0, 8'h03, "R2 inen reserved bits");
    pad_in = 8'hA5;
    wr_reg(4'd9, 8'h00);
    repeat (3) @(negedge clk);
    rd_reg(4'd10, 1'b0, 8'h00, "R2 inputs disabled");
    wr_reg(4'd9, 8'h02);
    rd_reg(4'd10, 1'b0, 8'h01, "R2 boot pins only");
    wr_reg(4'd9, 8'h01);
    rd_reg(4'd10, 1'b0, 8'hA5, "R6 direct read");

    // R3/R4/R5 data read paths
    wr_reg(4'd0, 8'h3C);
    rd_reg(4'd0, 1'b0, 8'hA5, "R3 input reads pin");
    rd_reg(4'd0, 1'b1, 8'h3C, "R4 rmw reads stored");
    settle();
    check({8'h0, pad_oe}, 16'h0, "R5 no drive in input");
    wr_reg(4'd1, 8'hF0);
    check({8'h0, pad_oe}, 16'h0, "R13 pad_oe not yet updated");
    settle();
    check({8'h0, pad_oe}, 16'h00F0, "R5 pad_oe follows dir");
    check({8'h0, pad_out & 8'hF0}, 16'h0030, "R5 pad_out stored");
    rd_reg(4'd0, 1'b0, 8'h35, "R3 mixed direction");
    rd_reg(4'd0, 1'b1, 8'h3C, "R4 rmw mixed direction");

    // R6 writes to direct address ignored
    wr_reg(4'd10, 8'hFF);
    rd_reg(4'd10, 1'b0, 8'hA5, "R6 write ignored");

    // R7 resource routing
    res1_out = 8'hFF; res1_oe = 8'h01; res2_out = 8'h00; res2_oe = 8'h02;
    wr_reg(4'd2, 8'h03);
    wr_reg(4'd3, 8'h02);
    settle();
    check({8'h0, pad_oe}, 16'h00F3, "R7 resource oe");
    check({8'h0, pad_out & 8'h03}, 16'h0001, "R7 resource out");
    check({8'h0, res1_in}, 16'h0001, "R7 res1_in");
    check({8'h0, res2_in}, 16'h0000, "R7 res2_in");
    rd_reg(4'd0, 1'b0, 8'h34, "R3 resource pins read stored");
    wr_reg(4'd2, 8'h00);
    wr_reg(4'd1, 8'h00);

    // R8/R9 pull decode and lock
    wr_reg(4'd5, 8'h0F);
    rd_reg(4'd5, 1'b0, 8'h0F, "R9 write while disabled");
    wr_reg(4'd4, 8'hFF);
    settle();
    check({8'h0, pad_pu}, 16'h000F, "R8 pull-up");
    check({8'h0, pad_pd}, 16'h00F0, "R8 pull-down");
    wr_reg(4'd5, 8'hF0);
    rd_reg(4'd5, 1'b0, 8'h0F, "R9 write while enabled ignored");
    settle();
    check({8'h0, pad_pu}, 16'h000F, "R9 pull-up unchanged");

    // R10/R11 output and stop mode
    wr_reg(4'd1, 8'h81);
    settle();
    check({8'h0, pad_pu}, 16'h000E, "R10 pull-up off on outputs");
    check({8'h0, pad_pd}, 16'h0070, "R10 pull-down off on outputs");
    @(negedge clk); hiz_stop = 1'b1;
    settle();
    check({8'h0, pad_oe}, 16'h0, "R11 hiz oe");
    check({8'h0, pad_pu | pad_pd}, 16'h0, "R10 hiz pulls");
    @(negedge clk); hiz_stop = 1'b0;
    settle();
    check({8'h0, pad_oe}, 16'h0081, "R11 oe restored");

    // R12 level code and drive
    wr_reg(4'd6, 8'h0F);
    wr_reg(4'd7, 8'h33);
    wr_reg(4'd8, 8'h5A);
    settle();
    check(pad_lvl, lvl_code(8'h0F, 8'h33), "R12 level codes");
    check({8'h0, pad_weak}, 16'h005A, "R12 weak drive");

    // R13 synchronizer latency: back-to-back direct reads across a pin change
    @(negedge clk);
    pad_in = 8'h0F; bus_rd = 1'b1; bus_addr = 4'd10;
    exp_q.push_back(8'hA5); tag_q.push_back("R13 stale first");
    @(negedge clk);
    exp_q.push_back(8'hA5); tag_q.push_back("R13 stale second");
    @(negedge clk);
    exp_q.push_back(8'h0F); tag_q.push_back("R13 new value");
    @(negedge clk);
    bus_rd = 1'b0;
    repeat (3) @(negedge clk);

    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule